// File: doc/BRIEF.md
# Four-Lane Sub-Vector Swizzle Unit

This unit reorders the four elements of a sub-vector. An 8-bit lane selector holds four 2-bit codes, and each code names the input lane that feeds one output lane. In the default single-source form, every output lane reads from operand A. In the two-source form, the two lower output lanes read from operand A and the two upper output lanes read from operand B. This lets one operation interleave halves of two vectors, in the style of a packed float shuffle.

The unit swizzles only when the function field carries the swizzle code and the sub-vector length is nonzero. In every other case operand A passes through untouched. A sub-vector length of one to three zeroes the output lanes at or above that length.

Results sit in a single output register. Both sides of the unit use valid/ready handshakes:
- A transfer on either side happens on a rising clock edge where valid and ready are both high.
- The unit takes a new input whenever its register is empty or the downstream side is taking the current result in the same cycle.
- While `out_valid` is high and `out_ready` is low, the stored result stays frozen and `in_ready` is low.

Top module: `swizzle4`

## Requirements
- R1: Output lane k, where x=0, y=1, z=2 and w=3, carries source element number `in_sel[2k+1:2k]`. Element j of an operand occupies bits `[j*ELEM_W +: ELEM_W]`.
- R2: When `in_sublen` is 0, the result equals `in_a` unchanged.
- R3: Swizzling happens only when `in_func` is 4'b0000. For any other value of `in_func`, the result equals `in_a` unchanged, whatever the selector, mode or length.
- R4: When `in_dual` is 1, output lanes 0 and 1 take their elements from `in_a` and output lanes 2 and 3 take theirs from `in_b`, each at the lane named by its code.
- R5: When all four codes equal i and both operands are the same, every output lane holds element i. This holds in both modes.
- R6: When swizzling is active and `in_sublen` is 1, 2 or 3, the output lanes with index at or above `in_sublen` are zero. When `in_sublen` is 4 or more, no lane is zeroed.
- R7: An input accepted on a clock edge appears on `out_data`, with `out_valid` high, right after that same edge.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R9: While `rst_n` is low, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer request |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_a | input | 4*ELEM_W | Operand A, four packed elements |
| in_b | input | 4*ELEM_W | Operand B, used for upper lanes in two-source mode |
| in_sel | input | 8 | Four 2-bit lane codes |
| in_dual | input | 1 | Two-source mode enable |
| in_sublen | input | 3 | Sub-vector length |
| in_func | input | 4 | Function code; 4'b0000 selects swizzle |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 4*ELEM_W | Swizzled result |

## Verification
The assertions assume the upstream side keeps every input stable and meaningful whenever it raises `in_valid`. They check properties only for inputs accepted while `in_ready` is high, and for the output only while downstream back-pressure is present.

The stimulus meets these assumptions. It changes inputs only on the falling clock edge. It holds each request until the cycle the modelled handshake accepts it. It drives `out_ready` randomly, so acceptance and stalls happen in both orders.

Stimulus coverage is as follows:
- All 256 selector values, in both modes.
- Every length value from 0 to 7.
- Non-swizzle function codes.
- Broadcasts with identical operands.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int LANES  = 4;
  localparam int CODE_W = $clog2(LANES);
  localparam int SEL_W  = LANES * CODE_W;
  localparam int LEN_W  = 3;
  localparam int FUNC_W = 4;
  localparam logic [FUNC_W-1:0] FUNC_SWIZZLE = 4'b0000;
endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  input  logic [LEN_W-1:0]  sublen,
  output logic              active,
  output logic [LANES-1:0]  keep
);
  always_comb begin
    active = (func == FUNC_SWIZZLE) && (sublen != '0);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_keep
    assign keep[k] = (sublen >= LEN_W'(LANES)) || (LEN_W'(k) < sublen);
  end
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux
  import swz_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int LANE   = 0
) (
  input  logic [LANES*ELEM_W-1:0] a,
  input  logic [LANES*ELEM_W-1:0] b,
  input  logic [CODE_W-1:0]       code,
  input  logic                    dual,
  input  logic                    active,
  input  logic                    keep,
  output logic [ELEM_W-1:0]       elem
);
  localparam bit UPPER = (LANE >= LANES / 2);

  logic [LANES*ELEM_W-1:0] src;
  logic [ELEM_W-1:0]       pick;

  always_comb begin
    src  = (dual && UPPER) ? b : a;
    pick = src[code*ELEM_W +: ELEM_W];
    if (!active)   elem = a[LANE*ELEM_W +: ELEM_W];
    else if (keep) elem = pick;
    else           elem = '0;
  end
endmodule

// File: rtl/swz_pipe.sv
module swz_pipe #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign up_ready = !vld_q || dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (up_ready) begin
      vld_q <= up_valid;
      if (up_valid) dat_q <= up_data;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));
  assert_take_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (dn_valid && dn_data == $past(up_data)));
endmodule

// File: rtl/swizzle4.sv
module swizzle4
  import swz_pkg::*;
#(
  parameter int ELEM_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ELEM_W-1:0] in_a,
  input  logic [LANES*ELEM_W-1:0] in_b,
  input  logic [SEL_W-1:0]        in_sel,
  input  logic                    in_dual,
  input  logic [LEN_W-1:0]        in_sublen,
  input  logic [FUNC_W-1:0]       in_func,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*ELEM_W-1:0] out_data
);
  localparam int VEC_W = LANES * ELEM_W;

  logic             active;
  logic [LANES-1:0] keep;
  logic [VEC_W-1:0] swz;

  swz_ctrl u_ctrl (
    .func   (in_func),
    .sublen (in_sublen),
    .active (active),
    .keep   (keep)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    swz_lane_mux #(.ELEM_W(ELEM_W), .LANE(k)) u_mux (
      .a      (in_a),
      .b      (in_b),
      .code   (in_sel[k*CODE_W +: CODE_W]),
      .dual   (in_dual),
      .active (active),
      .keep   (keep[k]),
      .elem   (swz[k*ELEM_W +: ELEM_W])
    );
  end

  swz_pipe #(.DATA_W(VEC_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (swz),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );

  assert_len0_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sublen == '0) |=> (out_data == $past(in_a)));
  assert_func_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_func != FUNC_SWIZZLE) |=> (out_data == $past(in_a)));
  assert_zero_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_func == FUNC_SWIZZLE && in_sublen == 3'd1)
    |=> (out_data[VEC_W-1:ELEM_W] == '0));
  assert_broadcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_func == FUNC_SWIZZLE && in_sublen >= 3'd4 && !in_dual
     && in_sel == {LANES{in_sel[CODE_W-1:0]}})
    |=> (out_data[ELEM_W-1:0] == out_data[VEC_W-1 -: ELEM_W]));
  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_R9: assert (!out_valid || $past(rst_n));
  end
endmodule

// File: tb/swizzle4_tb.sv
module swizzle4_tb;
  localparam int EW = 32;
  localparam int VW = 4 * EW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_a = '0;
  logic [VW-1:0] in_b = '0;
  logic [7:0]    in_sel = '0;
  logic          in_dual = 1'b0;
  logic [2:0]    in_sublen = '0;
  logic [3:0]    in_func = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VW-1:0] out_data;

  int checks = 0;
  int failures = 0;

  logic          mv = 1'b0;
  logic [VW-1:0] md = '0;
  string         mtag = "R9";

  always #5 clk = ~clk;

  swizzle4 #(.ELEM_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sel(in_sel), .in_dual(in_dual),
    .in_sublen(in_sublen), .in_func(in_func), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [VW-1:0] ref_swz(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic [7:0] s, input logic d,
                                            input logic [2:0] sl, input logic [3:0] f);
    logic [VW-1:0] r;
    if (f != 4'd0 || sl == 3'd0) return a;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      int code;
      logic [EW-1:0] e;
      code = (s >> (2 * k)) & 3;
      e = (d && k >= 2) ? b[code*EW +: EW] : a[code*EW +: EW];
      if (sl < 3'd4 && k >= int'(sl)) e = '0;
      r[k*EW +: EW] = e;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < 4; k++) v[k*EW +: EW] = $urandom();
    return v;
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [7:0] s, input logic d, input logic [2:0] sl,
                      input logic [3:0] f, input logic rdy, input string tag,
                      output logic acc);
    @(negedge clk);
    chk_bit({mtag, " R7 out_valid"}, out_valid, mv);
    if (mv) chk_vec(mtag, out_data, md);
    in_valid = v; in_a = a; in_b = b; in_sel = s; in_dual = d;
    in_sublen = sl; in_func = f; out_ready = rdy;
    #1;
    chk_bit("R8 in_ready", in_ready, !mv || rdy);
    acc = v && (!mv || rdy);
    if (!mv || rdy) begin
      mv = v;
      if (v) begin
        md = ref_swz(a, b, s, d, sl, f);
        mtag = tag;
      end
    end
  endtask

  task automatic send(input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [7:0] s,
                      input logic d, input logic [2:0] sl, input logic [3:0] f,
                      input string tag);
    logic acc;
    acc = 1'b0;
    while (!acc) step(1'b1, a, b, s, d, sl, f, ($urandom() % 4) != 0, tag, acc);
  endtask

  task automatic idle(input logic rdy);
    logic acc;
    step(1'b0, '0, '0, 8'h00, 1'b0, 3'd0, 4'd0, rdy, "idle", acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VW-1:0] va;
    logic acc;
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      chk_bit("R9 out_valid in reset", out_valid, 1'b0);
      chk_vec("R9 out_data in reset", out_data, '0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 and R4: every selector in both modes
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 256; s++) begin
        send(rnd_vec(), rnd_vec(), 8'(s), m[0], 3'd4, 4'd0, m ? "R4 dual" : "R1 single");
      end
    end

    // R2, R6: every length value
    for (int sl = 0; sl < 8; sl++) begin
      for (int t = 0; t < 6; t++) begin
        send(rnd_vec(), rnd_vec(), 8'($urandom()), t[0], 3'(sl), 4'd0,
             sl == 0 ? "R2 len0" : "R6 length");
      end
    end

    // R3: other function codes pass A through
    for (int f = 1; f < 16; f++) begin
      send(rnd_vec(), rnd_vec(), 8'($urandom()), f[0], 3'd4, 4'(f), "R3 func");
    end

    // R5: broadcast with identical operands
    for (int i = 0; i < 4; i++) begin
      for (int d = 0; d < 2; d++) begin
        logic [7:0] bs;
        bs = {4{2'(i)}};
        va = rnd_vec();
        send(va, va, bs, d[0], 3'd4, 4'd0, "R5 broadcast");
      end
    end

    // R7: single transfer with ready high
    idle(1'b1);
    step(1'b1, rnd_vec(), rnd_vec(), 8'h1b, 1'b0, 3'd4, 4'd0, 1'b1, "R7 latency", acc);
    idle(1'b1);
    idle(1'b1);

    // R8: stall holds data and blocks input
    step(1'b1, rnd_vec(), rnd_vec(), 8'he4, 1'b1, 3'd4, 4'd0, 1'b0, "R8 stall", acc);
    for (int t = 0; t < 5; t++)
      step(1'b1, rnd_vec(), rnd_vec(), 8'h39, 1'b0, 3'd4, 4'd0, 1'b0, "R8 stall", acc);
    idle(1'b1);
    idle(1'b1);
    idle(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule